// File: doc/BRIEF.md
# Bus Trace Sample Selector

This block decides, one bus clock at a time, whether the trace unit should capture a sample and whether that sample carries data. It watches two activity flags (address bus in use, data bus in use), a completion pulse per trace sequence from an external event matcher, and a control word per sequence. It drives a sample request with a data qualifier, trace function strobes (start, stop, freeze), a debug interrupt strobe for the processors, a clear-use strobe for the buffer, and an active-low debug pin.

A sequence whose 16-bit select value is all ones (every 4-bit field equal to 4'hF) is a wildcard. Its sample flags then ask for continuous per-cycle sampling, gated by bus activity, instead of one capture at completion. All sequences are evaluated in parallel and their requests are OR-merged into one sample and one set of strobes. The sample request is a one-cycle valid strobe with no ready input. The bus being traced cannot stall, so the consumer must take every request in the cycle it appears, and the block applies no back-pressure.

Control word layout (bit positions inside each `CTRL_W`-bit slice of `seq_ctrl`): [15:0] select, [16] addr-sample flag, [17] data-sample flag, [18] addr-on-data flag, [19] every-cycle flag, [21:20] function, [22] debug-pin flag, [23] debug-interrupt flag, [24] clear-use flag. Sequence i occupies `seq_ctrl[i*CTRL_W +: CTRL_W]`.

Top module: `bus_trace_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `smp_valid`, `smp_data`, `fn_start`, `fn_stop`, `fn_freeze`, `dbg_irq` and `clr_use` are 0 and `dbg_pin_n` is 1.
- R2: The function field is decoded as 00 nothing, 01 pulse `fn_start`, 10 pulse `fn_stop`, 11 pulse `fn_freeze`. The pulse appears in the cycle after the sequence's `seq_done` bit is high.
- R3: For a non-wildcard sequence with the addr-sample flag set and the data-sample flag clear, `seq_done` gives `smp_valid`=1 and `smp_data`=0 in the next cycle. A non-wildcard sequence never requests a sample when its `seq_done` bit is low.
- R4: For a non-wildcard sequence with the data-sample flag set, `seq_done` gives `smp_valid`=1 and `smp_data`=1 in the next cycle, whatever the addr-sample flag is. `smp_data` is never 1 without `smp_valid`.
- R5: For a wildcard sequence, the addr-sample flag requests an address-only sample in the cycle after every cycle with `addr_act`=1, regardless of `seq_done`.
- R6: For a wildcard sequence, the data-sample flag requests a sample with `smp_data`=1 in the cycle after every cycle with `data_act`=1.
- R7: For a wildcard sequence, the addr-on-data flag requests an address-only sample after every cycle with `data_act`=1.
- R8: For a wildcard sequence, the every-cycle flag requests a sample after every cycle, with or without bus activity.
- R9: Flags of a wildcard sequence combine by OR. With addr-sample and data-sample both set, a sample follows any active cycle and carries data only when `data_act` was 1. A select value with any field other than 4'hF is not a wildcard.
- R10: `seq_done` on a sequence with the debug-pin flag drives `dbg_pin_n` low in the next cycle. It stays low until a cycle with `dbg_release`=1 and no new pin request, which is followed by `dbg_pin_n`=1. A new request in the same cycle as a release wins.
- R11: `seq_done` on a sequence with the debug-interrupt flag or the clear-use flag gives a one-cycle `dbg_irq` or `clr_use` pulse in the next cycle.
- R12: Requests from several sequences in the same cycle are OR-merged, so one `smp_valid` and any mix of function strobes can appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_act | input | 1 | Address bus granted or used this cycle |
| data_act | input | 1 | Data bus granted or used this cycle |
| seq_done | input | NSEQ | Per-sequence completion pulse from the event matcher |
| seq_ctrl | input | NSEQ*CTRL_W | Packed control words, one per sequence |
| dbg_release | input | 1 | Releases the debug pin |
| smp_valid | output | 1 | Capture an address/control sample this cycle |
| smp_data | output | 1 | The sample also carries data |
| fn_start | output | 1 | Start trace collection strobe |
| fn_stop | output | 1 | Stop trace collection strobe |
| fn_freeze | output | 1 | Freeze trace buffer strobe |
| dbg_pin_n | output | 1 | Active-low debug pin, held |
| dbg_irq | output | 1 | Debug interrupt strobe to both processors |
| clr_use | output | 1 | Clear buffer use counter strobe |

## Verification
Every output except the debug pin is a single register stage, so a wrong decode, a wrong wildcard test or a lost merge shows at the ports in the cycle right after the stimulus. The sweep compares every cycle there. The debug pin is the only state that persists: a fault in its hold or release shows as a pin level that is wrong and stays wrong across later idle cycles, and the bench watches it across several of them. A wildcard check that is off by one field shows as samples that follow bus activity when they should follow `seq_done`, or the reverse.

// File: rtl/bus_trace_sel_pkg.sv
package bus_trace_sel_pkg;

  localparam int SEL_W = 16;

  typedef enum logic [1:0] {
    FN_NOP    = 2'b00,
    FN_START  = 2'b01,
    FN_STOP   = 2'b10,
    FN_FREEZE = 2'b11
  } trace_fn_e;

  // Per-sequence control word (MSB first in the packed struct).
  typedef struct packed {
    logic             clr_use;
    logic             dbg_cpu;
    logic             dbg_pin;
    trace_fn_e        func;
    logic             every_cyc;
    logic             addr_on_d;
    logic             d_smp;
    logic             a_smp;
    logic [SEL_W-1:0] sel;
  } seq_ctrl_t;

  localparam int CTRL_W = $bits(seq_ctrl_t);

  // Per-sequence request bundle produced by the evaluator.
  typedef struct packed {
    logic want_a;
    logic want_d;
    logic start;
    logic stop;
    logic freeze;
    logic pin;
    logic irq;
    logic clr;
  } seq_req_t;

endpackage

// File: rtl/bts_seq_eval.sv
module bts_seq_eval
  import bus_trace_sel_pkg::*;
(
  input  seq_ctrl_t ctrl,
  input  logic      done,
  input  logic      addr_act,
  input  logic      data_act,
  output seq_req_t  req
);

  logic wild;
  assign wild = &ctrl.sel;

  always_comb begin
    req = '0;
    if (wild) begin
      // Continuous sampling driven by bus activity.
      req.want_a = (ctrl.a_smp & addr_act)
                 | ((ctrl.d_smp | ctrl.addr_on_d) & data_act)
                 | ctrl.every_cyc;
      req.want_d = ctrl.d_smp & data_act;
    end else if (done) begin
      // One-shot capture; data-sample overrides addr-sample.
      if (ctrl.d_smp) begin
        req.want_a = 1'b1;
        req.want_d = 1'b1;
      end else if (ctrl.a_smp) begin
        req.want_a = 1'b1;
      end
    end
    if (done) begin
      unique case (ctrl.func)
        FN_START:  req.start  = 1'b1;
        FN_STOP:   req.stop   = 1'b1;
        FN_FREEZE: req.freeze = 1'b1;
        default:   ;
      endcase
      req.pin = ctrl.dbg_pin;
      req.irq = ctrl.dbg_cpu;
      req.clr = ctrl.clr_use;
    end
  end

endmodule

// File: rtl/bts_out_stage.sv
module bts_out_stage
  import bus_trace_sel_pkg::*;
#(
  parameter int NSEQ = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  seq_req_t reqs [NSEQ],
  input  logic     dbg_release,
  output logic     smp_valid,
  output logic     smp_data,
  output logic     fn_start,
  output logic     fn_stop,
  output logic     fn_freeze,
  output logic     dbg_pin_n,
  output logic     dbg_irq,
  output logic     clr_use
);

  seq_req_t merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < NSEQ; i++) begin
      merged = merged | reqs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= 1'b0;
      fn_start  <= 1'b0;
      fn_stop   <= 1'b0;
      fn_freeze <= 1'b0;
      dbg_irq   <= 1'b0;
      clr_use   <= 1'b0;
      dbg_pin_n <= 1'b1;
    end else begin
      smp_valid <= merged.want_a | merged.want_d;
      smp_data  <= merged.want_d;
      fn_start  <= merged.start;
      fn_stop   <= merged.stop;
      fn_freeze <= merged.freeze;
      dbg_irq   <= merged.irq;
      clr_use   <= merged.clr;
      if (merged.pin)       dbg_pin_n <= 1'b0;
      else if (dbg_release) dbg_pin_n <= 1'b1;
    end
  end

  // R10: a low pin stays low unless released.
  a_r10_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(dbg_pin_n) && !$past(dbg_release) |-> !dbg_pin_n);

  // R10: a release with no competing request lets the pin go high.
  a_r10_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dbg_release) && !$past(merged.pin) |-> dbg_pin_n);

endmodule

// File: rtl/bus_trace_sel.sv
module bus_trace_sel
  import bus_trace_sel_pkg::*;
#(
  parameter int NSEQ = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_act,
  input  logic                   data_act,
  input  logic [NSEQ-1:0]        seq_done,
  input  logic [NSEQ*CTRL_W-1:0] seq_ctrl,
  input  logic                   dbg_release,
  output logic                   smp_valid,
  output logic                   smp_data,
  output logic                   fn_start,
  output logic                   fn_stop,
  output logic                   fn_freeze,
  output logic                   dbg_pin_n,
  output logic                   dbg_irq,
  output logic                   clr_use
);

  seq_ctrl_t ctrl_arr [NSEQ];
  seq_req_t  req_arr  [NSEQ];

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    assign ctrl_arr[g] = seq_ctrl[g*CTRL_W +: CTRL_W];
    bts_seq_eval u_eval (
      .ctrl     (ctrl_arr[g]),
      .done     (seq_done[g]),
      .addr_act (addr_act),
      .data_act (data_act),
      .req      (req_arr[g])
    );
  end

  bts_out_stage #(.NSEQ(NSEQ)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqs        (req_arr),
    .dbg_release (dbg_release),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .fn_start    (fn_start),
    .fn_stop     (fn_stop),
    .fn_freeze   (fn_freeze),
    .dbg_pin_n   (dbg_pin_n),
    .dbg_irq     (dbg_irq),
    .clr_use     (clr_use)
  );

  // Checker-side view of the control words, separate from the evaluators.
  logic any_wild, any_every;
  always_comb begin
    any_wild  = 1'b0;
    any_every = 1'b0;
    for (int i = 0; i < NSEQ; i++) begin
      if (seq_ctrl[i*CTRL_W +: SEL_W] == {SEL_W{1'b1}}) begin
        any_wild = 1'b1;
        if (ctrl_arr[i].every_cyc) any_every = 1'b1;
      end
    end
  end

  // R8: an every-cycle wildcard sequence samples each cycle.
  a_r8_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(any_every) |-> smp_valid);

  // R3: with no completions and no wildcard, nothing is requested.
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(seq_done == '0) && !$past(any_wild)
      |-> !smp_valid && !fn_start && !fn_stop && !fn_freeze && !dbg_irq && !clr_use);

  // R4: a data sample always carries address/control.
  a_r4_data_has_addr: assert property (@(posedge clk) disable iff (!rst_n)
    smp_data |-> smp_valid);

endmodule

// File: tb/tb_bus_trace_sel.sv
`timescale 1ns/1ps
module tb_bus_trace_sel;
  import bus_trace_sel_pkg::*;

  localparam int NSEQ = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic addr_act, data_act, dbg_release;
  logic [NSEQ-1:0] seq_done;
  logic [NSEQ*CTRL_W-1:0] seq_ctrl;
  logic smp_valid, smp_data, fn_start, fn_stop, fn_freeze, dbg_pin_n, dbg_irq, clr_use;

  seq_ctrl_t cw [NSEQ];
  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NSEQ; i++) seq_ctrl[i*CTRL_W +: CTRL_W] = cw[i];

  bus_trace_sel #(.NSEQ(NSEQ)) dut (
    .clk(clk), .rst_n(rst_n), .addr_act(addr_act), .data_act(data_act),
    .seq_done(seq_done), .seq_ctrl(seq_ctrl), .dbg_release(dbg_release),
    .smp_valid(smp_valid), .smp_data(smp_data), .fn_start(fn_start),
    .fn_stop(fn_stop), .fn_freeze(fn_freeze), .dbg_pin_n(dbg_pin_n),
    .dbg_irq(dbg_irq), .clr_use(clr_use)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected outputs: {valid, data, start, stop, freeze, irq, clr}
  function automatic logic [6:0] model(input logic [NSEQ-1:0] dn, input logic a, input logic d);
    logic v = 0, dt = 0, st = 0, sp = 0, fz = 0, irq = 0, cl = 0;
    for (int i = 0; i < NSEQ; i++) begin
      if (cw[i].sel == 16'hFFFF) begin
        if ((cw[i].a_smp && a) || ((cw[i].d_smp || cw[i].addr_on_d) && d) || cw[i].every_cyc) v = 1;
        if (cw[i].d_smp && d) dt = 1;
      end else if (dn[i]) begin
        if (cw[i].a_smp || cw[i].d_smp) v = 1;
        if (cw[i].d_smp) dt = 1;
      end
      if (dn[i]) begin
        if (cw[i].func == 2'd1) st = 1;
        if (cw[i].func == 2'd2) sp = 1;
        if (cw[i].func == 2'd3) fz = 1;
        if (cw[i].dbg_cpu) irq = 1;
        if (cw[i].clr_use) cl = 1;
      end
    end
    return {v, dt, st, sp, fz, irq, cl};
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [6:0] e;
    rst_n = 0; addr_act = 0; data_act = 0; dbg_release = 0; seq_done = '0;
    for (int i = 0; i < NSEQ; i++) cw[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 reset", {1'b0, smp_valid, smp_data, fn_start, fn_stop, fn_freeze, dbg_irq, clr_use}, 8'h00);
    chk("R1 reset pin", {7'b0, dbg_pin_n}, 8'h01);
    rst_n = 1;
    step();
    chk("R1 after reset", {1'b0, smp_valid, smp_data, fn_start, fn_stop, fn_freeze, dbg_irq, clr_use}, 8'h00);

    // Sweep sequence 0 over select kind, flags, and bus/done patterns.
    for (int w = 0; w < 3; w++) begin
      for (int f = 0; f < 16; f++) begin
        for (int p = 0; p < 8; p++) begin
          cw[0] = '0;
          cw[0].sel       = (w == 0) ? 16'h0000 : (w == 1) ? 16'hFFFF : 16'hFFFE;
          cw[0].a_smp     = f[0];
          cw[0].d_smp     = f[1];
          cw[0].addr_on_d = f[2];
          cw[0].every_cyc = f[3];
          cw[0].func      = trace_fn_e'(f[1:0] ^ p[1:0]);
          cw[0].dbg_cpu   = f[2];
          cw[0].clr_use   = f[3] ^ p[0];
          addr_act    = p[0];
          data_act    = p[1];
          seq_done    = {{(NSEQ-1){1'b0}}, p[2]};
          e = model(seq_done, addr_act, data_act);
          step();
          if (w == 1)
            chk("R5/R6/R7/R8/R9 wildcard sample", {6'b0, smp_valid, smp_data}, {6'b0, e[6:5]});
          else
            chk("R3/R4/R9 one-shot sample", {6'b0, smp_valid, smp_data}, {6'b0, e[6:5]});
          chk("R2 function strobe", {5'b0, fn_start, fn_stop, fn_freeze}, {5'b0, e[4:2]});
          chk("R11 irq/clear strobe", {6'b0, dbg_irq, clr_use}, {6'b0, e[1:0]});
        end
      end
    end
    seq_done = '0; addr_act = 0; data_act = 0;
    for (int i = 0; i < NSEQ; i++) cw[i] = '0;
    step();
    chk("R11 strobes single cycle", {6'b0, dbg_irq, clr_use}, 8'h00);

    // R12: merge across sequences.
    cw[2].a_smp = 1; cw[2].func = FN_START;
    cw[5].d_smp = 1; cw[5].func = FN_STOP;
    cw[7].func  = FN_FREEZE; cw[7].dbg_cpu = 1;
    seq_done = 8'b1010_0100;
    step();
    chk("R12 merged sample", {6'b0, smp_valid, smp_data}, 8'h03);
    chk("R12 merged functions", {4'b0, fn_start, fn_stop, fn_freeze, dbg_irq}, 8'h0F);
    seq_done = 8'b0000_0100;
    cw[6].sel = 16'hFFFF; cw[6].every_cyc = 1;
    step();
    chk("R12 one-shot plus every-cycle", {6'b0, smp_valid, smp_data}, 8'h02);
    seq_done = '0;
    step();
    chk("R8 every cycle idle bus", {6'b0, smp_valid, smp_data}, 8'h02);
    for (int i = 0; i < NSEQ; i++) cw[i] = '0;
    step();
    chk("R3 idle no sample", {6'b0, smp_valid, smp_data}, 8'h00);

    // R10: debug pin hold and release.
    cw[4].dbg_pin = 1;
    seq_done = 8'b0001_0000;
    step();
    chk("R10 pin driven low", {7'b0, dbg_pin_n}, 8'h00);
    seq_done = '0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R10 pin held low", {7'b0, dbg_pin_n}, 8'h00);
    end
    dbg_release = 1;
    step();
    chk("R10 pin released", {7'b0, dbg_pin_n}, 8'h01);
    dbg_release = 0;
    step();
    chk("R10 pin stays high", {7'b0, dbg_pin_n}, 8'h01);
    dbg_release = 1;
    step();
    chk("R10 release when high", {7'b0, dbg_pin_n}, 8'h01);
    seq_done = 8'b0001_0000;
    step();
    chk("R10 request beats release", {7'b0, dbg_pin_n}, 8'h00);
    seq_done = '0;
    step();
    chk("R10 released after tie", {7'b0, dbg_pin_n}, 8'h01);
    dbg_release = 0;

    finish_run();
  end

endmodule